// File: doc/BRIEF.md
# Single-Wire Bit-Slot Serial Transmitter

This block sends fixed-length frames from one master to any number of listeners over a single wire. The wire idles high and can only be pulled low. There is no shared clock. Every bit gets a slot of fixed length. A slot opens with the line pulled low, which marks the start of the bit for a receiver with a loose clock. Next comes a data phase whose level carries the bit. The slot closes with a high recovery phase. Each frame starts with one marker slot in which the line stays low for the whole slot. A listener that sees a low run longer than a slot clears its bit counter.

The frame word is loaded in parallel through a valid/ready stream handshake. A word is taken on a rising clock edge where `frame_valid_i` and `frame_ready_o` are both high. `frame_ready_o` then stays low for the whole frame. This back-pressure is the only flow control. While ready is low, the valid and data inputs are ignored, and a source holding valid simply waits. Slot timing comes from cycle-count parameters. The default is a 1000-cycle slot split 250 low, 250 data and 500 recovery, which gives about 20 kbit/s from a 20 MHz clock.

Top module: `slot_line_tx`

## Requirements
- R1: After reset, and whenever no frame is in flight, `frame_ready_o` is 1 and `line_o` is 1 (released high).
- R2: Each data slot lasts BIT_CYC cycles: LOW_CYC cycles low, then DATA_CYC cycles at the data level, then BIT_CYC-LOW_CYC-DATA_CYC cycles high.
- R3: A frame is one marker slot followed by FRAME_BITS data slots (32 by default). Bits are sent most significant first, so bit FRAME_BITS-1 (the top of the address byte) goes in the first data slot.
- R4: The marker slot starts in the cycle after acceptance and holds `line_o` at 0 for all BIT_CYC cycles.
- R5: In the data phase, a 1 bit drives `line_o` to 0 and a 0 bit leaves `line_o` at 1.
- R6: A word is accepted when `frame_valid_i` and `frame_ready_o` are both 1 at a rising edge. From the next cycle, `frame_ready_o` is 0 until the last data slot's recovery phase ends, and it is 1 in the cycle after that. While `frame_ready_o` is 0, changes on `frame_valid_i` and `frame_data_i` do not alter the bits on the line.
- R7: Back-to-back frames are separated by at least one idle high cycle. The next marker slot follows directly after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_valid_i | input | 1 | Frame word offered |
| frame_ready_o | output | 1 | Block idle and able to take a word |
| frame_data_i | input | FRAME_BITS | Frame word, sent MSB first |
| line_o | output | 1 | Serial line level, 1 = released high |

## Verification
The bench compares the line against the expected level in every cycle of every slot. A phase that is off by one cycle, or bits sent in the wrong order, therefore shows up as a mismatch in that slot. It sends all-zero and all-one words and words with only the end bits set. These catch a missing or shortened marker slot and a data polarity that is inverted. It also pulses valid with different data in the middle of a frame. A design that reloaded or shifted on that pulse would corrupt the remaining bits. Back-to-back sends check the exact cycle where ready returns. A design that released ready early, or held it low one cycle too long, would fail that check.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  typedef enum logic [1:0] {
    PH_LOW  = 2'd0,
    PH_DATA = 2'd1,
    PH_WAIT = 2'd2
  } phase_t;
endpackage

// File: rtl/bsl_slot_timer.sv
module bsl_slot_timer
  import bsl_pkg::*;
#(
  parameter int LOW_CYC  = 250,
  parameter int DATA_CYC = 250,
  parameter int WAIT_CYC = 500
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run_i,
  output phase_t phase_o,
  output logic   slot_end_o
);
  localparam int SLOT_CYC = LOW_CYC + DATA_CYC + WAIT_CYC;
  localparam int CW       = $clog2(SLOT_CYC + 1);

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;
  logic          low_done, data_done, wait_done;

  assign low_done   = (cnt_q == CW'(LOW_CYC - 1));
  assign data_done  = (cnt_q == CW'(DATA_CYC - 1));
  assign wait_done  = (cnt_q == CW'(WAIT_CYC - 1));
  assign phase_o    = phase_q;
  assign slot_end_o = run_i && (phase_q == PH_WAIT) && wait_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
    end else if (!run_i) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_LOW: begin
          if (low_done) begin
            phase_q <= PH_DATA;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_DATA: begin
          if (data_done) begin
            phase_q <= PH_WAIT;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_WAIT: begin
          if (wait_done) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          phase_q <= PH_LOW;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW  -> cnt_q < CW'(LOW_CYC)) &&
    (phase_q == PH_DATA -> cnt_q < CW'(DATA_CYC)) &&
    (phase_q == PH_WAIT -> cnt_q < CW'(WAIT_CYC))); // R2

  AST_LOW_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && phase_q == PH_LOW && low_done |=> phase_q == PH_DATA || !run_i); // R2
endmodule

// File: rtl/bsl_frame_seq.sv
module bsl_frame_seq #(
  parameter int FRAME_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  slot_end_i,
  output logic                  busy_o,
  output logic                  marker_o,
  output logic                  bit_o
);
  localparam int IW = $clog2(FRAME_BITS + 1);

  logic                  busy_q;
  logic [IW-1:0]         idx_q;
  logic [FRAME_BITS-1:0] sreg_q;

  assign busy_o   = busy_q;
  assign marker_o = (idx_q == '0);
  assign bit_o    = sreg_q[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sreg_q <= '0;
    end else if (!busy_q) begin
      if (accept_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        sreg_q <= frame_i;
      end
    end else if (slot_end_i) begin
      if (idx_q == IW'(FRAME_BITS)) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
        if (idx_q != '0) sreg_q <= sreg_q << 1;
      end
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IW'(FRAME_BITS)); // R3

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !slot_end_i |=> $stable(sreg_q)); // R6
endmodule

// File: rtl/slot_line_tx.sv
module slot_line_tx
  import bsl_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  parameter int BIT_CYC    = 1000,
  parameter int LOW_CYC    = 250,
  parameter int DATA_CYC   = 250
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_valid_i,
  output logic                  frame_ready_o,
  input  logic [FRAME_BITS-1:0] frame_data_i,
  output logic                  line_o
);
  localparam int WAIT_CYC = BIT_CYC - LOW_CYC - DATA_CYC;

  phase_t phase;
  logic   slot_end, busy, marker, cur_bit, accept;

  assign frame_ready_o = !busy;
  assign accept        = frame_valid_i && !busy;

  bsl_slot_timer #(
    .LOW_CYC (LOW_CYC),
    .DATA_CYC(DATA_CYC),
    .WAIT_CYC(WAIT_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (busy),
    .phase_o   (phase),
    .slot_end_o(slot_end)
  );

  bsl_frame_seq #(
    .FRAME_BITS(FRAME_BITS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept),
    .frame_i   (frame_data_i),
    .slot_end_i(slot_end),
    .busy_o    (busy),
    .marker_o  (marker),
    .bit_o     (cur_bit)
  );

  always_comb begin
    if (!busy)       line_o = 1'b1;
    else if (marker) line_o = 1'b0;
    else begin
      case (phase)
        PH_LOW:  line_o = 1'b0;
        PH_DATA: line_o = !cur_bit;
        default: line_o = 1'b1;
      endcase
    end
  end

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid_i && frame_ready_o |=> !frame_ready_o); // R6

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready_o |-> line_o); // R1
endmodule

// File: tb/tb_slot_line_tx.sv
module tb_slot_line_tx;
  localparam int FB   = 32;
  localparam int BITC = 10;
  localparam int LOWC = 3;
  localparam int DATC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_valid_i = 1'b0;
  logic [FB-1:0] frame_data_i = '0;
  logic          frame_ready_o, line_o;

  int total = 0;
  int bad   = 0;
  logic [FB-1:0] q[$];
  bit mon_busy = 1'b0;

  always #2.5 clk = ~clk;

  slot_line_tx #(.FRAME_BITS(FB), .BIT_CYC(BITC), .LOW_CYC(LOWC), .DATA_CYC(DATC)) dut (
    .clk(clk), .rst_n(rst_n), .frame_valid_i(frame_valid_i),
    .frame_ready_o(frame_ready_o), .frame_data_i(frame_data_i), .line_o(line_o));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_level(logic [FB-1:0] w, int s, int c);
    if (s == 0) return 1'b0;
    if (c < LOWC) return 1'b0;
    if (c < LOWC + DATC) return !w[FB-s];
    return 1'b1;
  endfunction

  // driver: offer a word, push it when acceptance is certain
  task automatic send(logic [FB-1:0] w);
    @(negedge clk);
    frame_valid_i = 1'b1;
    frame_data_i  = w;
    while (!frame_ready_o) @(negedge clk);
    q.push_back(w);
    @(negedge clk);
    check("R6 ready low after accept", {31'd0, frame_ready_o}, 32'd0);
    frame_valid_i = 1'b0;
    frame_data_i  = ~w;
  endtask

  // monitor: decode line cycle by cycle
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !line_o) begin
        logic [FB-1:0] w;
        int rdy_err;
        mon_busy = 1'b1;
        rdy_err = 0;
        if (q.size() == 0) begin
          check("R6 unexpected frame", 32'd1, 32'd0);
          w = '0;
        end else w = q.pop_front();
        for (int s = 0; s <= FB; s++) begin
          int errs;
          errs = 0;
          for (int c = 0; c < BITC; c++) begin
            if (!(s == 0 && c == 0)) @(negedge clk);
            if (line_o !== exp_level(w, s, c)) errs++;
            if (frame_ready_o !== 1'b0) rdy_err++;
          end
          if (s == 0) check("R4 marker slot all low", errs, 0);
          else        check("R2 R3 R5 data slot shape", errs, 0);
        end
        check("R6 ready low through frame", rdy_err, 0);
        @(negedge clk);
        check("R6 ready back after frame", {31'd0, frame_ready_o}, 32'd1);
        check("R7 idle high gap", {31'd0, line_o}, 32'd1);
        mon_busy = 1'b0;
      end
    end
  end

  task automatic drain();
    @(negedge clk);
    while (q.size() != 0 || mon_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {31'd0, frame_ready_o}, 32'd1);
    check("R1 line high in reset", {31'd0, line_o}, 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ready idle", {31'd0, frame_ready_o}, 32'd1);
    check("R1 line idle", {31'd0, line_o}, 32'd1);

    send(32'hA512_34FF); drain();
    send(32'h0000_0000); drain();
    send(32'hFFFF_FFFF); drain();
    send(32'h8000_0001); drain();

    // R6: valid pulses with other data mid-frame must be ignored
    send(32'h1234_5678);
    repeat (40) @(negedge clk);
    frame_valid_i = 1'b1; frame_data_i = 32'hDEAD_BEEF;
    @(negedge clk);
    frame_valid_i = 1'b0; frame_data_i = 32'h0F0F_0F0F;
    repeat (25) @(negedge clk);
    frame_valid_i = 1'b1;
    @(negedge clk);
    frame_valid_i = 1'b0;
    drain();

    // R7: back-to-back frames, valid held while waiting
    send(32'hC3C3_5AA5);
    send(32'h7FFF_FFFE);
    send(32'h0102_0304);
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule